// File: doc/BRIEF.md
# Supply-Present Poller and Bus Drive Controller

This block decides, from a periodically polled supply-present pin, whether the device may present itself on the upstream bus and how the downstream disk-interface pin group behaves. The raw pin passes through a two-flop synchronizer. A prescaler then takes a sample shortly after reset and once per poll interval after that, which is 20 ms at the intended clock. Each sample is held unchanged until the next one, so every pin-group enable that depends on it changes only at a poll boundary.

From the held sample, the block drives several outputs:
- the D+ pull-up enable;
- one output-enable for the whole disk-interface pin group;
- the value and output-enable of the disk-bus pull-up control.

A configuration input selects what the disk pins do while the supply is absent. They either float, or stay driven at their idle levels.

Two further outputs come only from the suspend input:
- a low-power indicator, which drives 0 when awake and floats in suspend;
- a high-current-allowed flag.

Tristate pins are shown as a value and an enable. The pad ring builds the actual buffers.

Top module: `vbus_bus_ctl`

## Requirements
- R1: While reset is held, and after release until the first poll, the held sample is 0. The first poll happens on the third rising clock edge after reset release and captures the pin level present at the first edge.
- R2: After the first poll, polls recur every POLL_DIV clock cycles. Between polls, changes on the supply pin do not affect any output.
- R3: A poll on edge n captures the pin level seen at edge n-2, which is the two-flop synchronizer latency. A pulse that is not present at that edge is missed.
- R4: `dp_pullup_en_o` equals the held sample (1 = supply present).
- R5: With `cfg_float_i`=1 and a held sample of 0, `ata_oe_o` and `ata_pu_oe_o` are both 0, so the whole pin group floats.
- R6: With `cfg_float_i`=0 and a held sample of 0, `ata_oe_o`=1, `ata_pu_oe_o`=1 and `ata_pu_o`=0, so the pins are driven idle.
- R7: With a held sample of 1, `ata_oe_o`=1, `ata_pu_oe_o`=1 and `ata_pu_o` equals `ata_active_i`.
- R8: `lowpwr_o` is always 0, and `lowpwr_oe_o` is 1 exactly when `suspend_i` is 0.
- R9: `hicur_o` is 1 exactly when `suspend_i` is 0. It therefore drops on entry to suspend and comes back on resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the reset tree |
| vbus_pin | input | 1 | Raw supply-present pin, asynchronous |
| suspend_i | input | 1 | 1 while the device is suspended |
| ata_active_i | input | 1 | 1 while the disk bus is active |
| cfg_float_i | input | 1 | 1: disk pins float when the supply is absent; 0: they are driven idle |
| dp_pullup_en_o | output | 1 | D+ pull-up enable |
| ata_oe_o | output | 1 | Output-enable for the whole disk-interface pin group |
| ata_pu_o | output | 1 | Disk-bus pull-up control value |
| ata_pu_oe_o | output | 1 | Output-enable of the pull-up control |
| lowpwr_o | output | 1 | Low-power indicator value (always 0) |
| lowpwr_oe_o | output | 1 | Low-power indicator enable |
| hicur_o | output | 1 | High-current-allowed flag |

## Verification
The hardest case to reach from the ports is a supply pin pulse that lasts one clock and sits exactly on the edge the next poll reads, two cycles before the poll. A pulse that misses that edge by one cycle must instead be ignored. Random stimulus seldom lines such pulses up with the poll phase. A directed phase therefore uses the bench's own count of edges since reset to place one-cycle pulses on the captured edge, and also one cycle off it, while the other inputs keep changing at random. The bench checks every cycle against an expected sample that it derives from the poll schedule.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

  // Depth of the pin synchronizer; poll timing is derived from it.
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic dp_pu;
    logic ata_oe;
    logic ata_pu;
    logic ata_pu_oe;
    logic lowpwr;
    logic lowpwr_oe;
    logic hicur;
  } vbc_pins_t;

endpackage

// File: rtl/vbc_sync.sv
module vbc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/vbc_poll_timer.sv
module vbc_poll_timer #(
  parameter int unsigned POLL_DIV  = 4_000_000,
  parameter int unsigned START_LAG = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int unsigned CNT_W     = (POLL_DIV > 1) ? $clog2(POLL_DIV) : 1;
  localparam int unsigned LAST      = POLL_DIV - 1;
  // Preload so the first tick lands once the synchronizer has filled.
  localparam int unsigned START_CNT = POLL_DIV - 1 - START_LAG;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == CNT_W'(LAST));

  always_comb begin
    if (at_last) cnt_d = '0;
    else         cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(START_CNT);
    else        cnt_q <= cnt_d;
  end

  assign tick_o = at_last;

endmodule

// File: rtl/vbc_out_ctl.sv
module vbc_out_ctl
  import vbc_pkg::*;
(
  input  logic      present_i,
  input  logic      suspend_i,
  input  logic      ata_active_i,
  input  logic      cfg_float_i,
  output vbc_pins_t pins_o
);

  logic drive_grp;

  always_comb begin
    drive_grp        = present_i | ~cfg_float_i;
    pins_o.dp_pu     = present_i;
    pins_o.ata_oe    = drive_grp;
    pins_o.ata_pu_oe = drive_grp;
    pins_o.ata_pu    = present_i & ata_active_i;
    pins_o.lowpwr    = 1'b0;
    pins_o.lowpwr_oe = ~suspend_i;
    pins_o.hicur     = ~suspend_i;
  end

endmodule

// File: rtl/vbus_bus_ctl.sv
module vbus_bus_ctl
  import vbc_pkg::*;
#(
  parameter int unsigned POLL_DIV = 4_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vbus_pin,
  input  logic suspend_i,
  input  logic ata_active_i,
  input  logic cfg_float_i,
  output logic dp_pullup_en_o,
  output logic ata_oe_o,
  output logic ata_pu_o,
  output logic ata_pu_oe_o,
  output logic lowpwr_o,
  output logic lowpwr_oe_o,
  output logic hicur_o
);

  logic      vbus_sync;
  logic      poll_tick;
  logic      present_q;
  logic      present_d;
  vbc_pins_t pins;

  vbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (vbus_pin),
    .q_o   (vbus_sync)
  );

  vbc_poll_timer #(.POLL_DIV(POLL_DIV), .START_LAG(SYNC_STAGES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (poll_tick)
  );

  // Held sample: loads only on a poll tick.
  always_comb begin
    present_d = present_q;
    if (poll_tick) present_d = vbus_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) present_q <= 1'b0;
    else        present_q <= present_d;
  end

  vbc_out_ctl u_out (
    .present_i    (present_q),
    .suspend_i    (suspend_i),
    .ata_active_i (ata_active_i),
    .cfg_float_i  (cfg_float_i),
    .pins_o       (pins)
  );

  assign dp_pullup_en_o = pins.dp_pu;
  assign ata_oe_o       = pins.ata_oe;
  assign ata_pu_o       = pins.ata_pu;
  assign ata_pu_oe_o    = pins.ata_pu_oe;
  assign lowpwr_o       = pins.lowpwr;
  assign lowpwr_oe_o    = pins.lowpwr_oe;
  assign hicur_o        = pins.hicur;

endmodule

// File: rtl/vbus_bus_ctl_chk.sv
module vbus_bus_ctl_chk #(
  parameter int unsigned POLL_DIV = 4_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic poll_tick,
  input logic suspend_i,
  input logic ata_active_i,
  input logic cfg_float_i,
  input logic dp_pullup_en_o,
  input logic ata_oe_o,
  input logic ata_pu_o,
  input logic ata_pu_oe_o,
  input logic lowpwr_o,
  input logic lowpwr_oe_o,
  input logic hicur_o
);

  localparam int unsigned GAP_W = $clog2(POLL_DIV) + 1;

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (poll_tick) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + GAP_W'(1);
    end
  end

  AST_POLL_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && poll_tick) |-> (gap_q == GAP_W'(POLL_DIV - 1))); // R2

  AST_DP_ONLY_AT_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_pullup_en_o != $past(dp_pullup_en_o)) |-> $past(poll_tick)); // R4

  AST_FLOAT_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_float_i && !dp_pullup_en_o) |-> (!ata_oe_o && !ata_pu_oe_o)); // R5

  AST_IDLE_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_float_i && !dp_pullup_en_o) |-> (ata_oe_o && ata_pu_oe_o && !ata_pu_o)); // R6

  AST_PU_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dp_pullup_en_o |-> (ata_oe_o && ata_pu_oe_o && (ata_pu_o == ata_active_i))); // R7

  AST_LOWPWR_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!lowpwr_o && (lowpwr_oe_o == !suspend_i))); // R8

  AST_HICUR_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (hicur_o == !suspend_i)); // R9

endmodule

bind vbus_bus_ctl vbus_bus_ctl_chk #(.POLL_DIV(POLL_DIV)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .poll_tick      (poll_tick),
  .suspend_i      (suspend_i),
  .ata_active_i   (ata_active_i),
  .cfg_float_i    (cfg_float_i),
  .dp_pullup_en_o (dp_pullup_en_o),
  .ata_oe_o       (ata_oe_o),
  .ata_pu_o       (ata_pu_o),
  .ata_pu_oe_o    (ata_pu_oe_o),
  .lowpwr_o       (lowpwr_o),
  .lowpwr_oe_o    (lowpwr_oe_o),
  .hicur_o        (hicur_o)
);

// File: tb/vbus_bus_ctl_tb_top.sv
`timescale 1ns/1ps
module vbus_bus_ctl_tb_top;

  localparam int unsigned P = 16;

  logic clk;
  logic rst_n;
  logic vbus_pin;
  logic suspend_i;
  logic ata_active_i;
  logic cfg_float_i;
  logic dp_pullup_en_o;
  logic ata_oe_o;
  logic ata_pu_o;
  logic ata_pu_oe_o;
  logic lowpwr_o;
  logic lowpwr_oe_o;
  logic hicur_o;

  int n_checks;
  int n_fail;
  bit done;

  vbus_bus_ctl #(.POLL_DIV(P)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .vbus_pin       (vbus_pin),
    .suspend_i      (suspend_i),
    .ata_active_i   (ata_active_i),
    .cfg_float_i    (cfg_float_i),
    .dp_pullup_en_o (dp_pullup_en_o),
    .ata_oe_o       (ata_oe_o),
    .ata_pu_o       (ata_pu_o),
    .ata_pu_oe_o    (ata_pu_oe_o),
    .lowpwr_o       (lowpwr_o),
    .lowpwr_oe_o    (lowpwr_oe_o),
    .hicur_o        (hicur_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Expected pin-group outputs from the held sample and the live inputs.
  function automatic logic exp_ata_oe(input logic v, input logic flt);
    return v | ~flt;
  endfunction

  function automatic logic exp_ata_pu(input logic v, input logic act);
    return v & act;
  endfunction

  task automatic check_all(input logic ev);
    check(ev ? "R4" : "R4", "dp_pullup_en", dp_pullup_en_o, ev);
    if (!ev && cfg_float_i) begin
      check("R5", "ata_oe", ata_oe_o, 1'b0);
      check("R5", "ata_pu_oe", ata_pu_oe_o, 1'b0);
    end else if (!ev) begin
      check("R6", "ata_oe", ata_oe_o, 1'b1);
      check("R6", "ata_pu_oe", ata_pu_oe_o, 1'b1);
      check("R6", "ata_pu", ata_pu_o, 1'b0);
    end else begin
      check("R7", "ata_oe", ata_oe_o, exp_ata_oe(ev, cfg_float_i));
      check("R7", "ata_pu_oe", ata_pu_oe_o, 1'b1);
      check("R7", "ata_pu", ata_pu_o, exp_ata_pu(ev, ata_active_i));
    end
    check("R8", "lowpwr", lowpwr_o, 1'b0);
    check("R8", "lowpwr_oe", lowpwr_oe_o, ~suspend_i);
    check("R9", "hicur", hicur_o, ~suspend_i);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic exp_v;
    logic h1;
    logic h2;
    int   n;
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    void'($urandom(32'h5EED_0042));
    rst_n        = 1'b0;
    vbus_pin     = 1'b1;
    suspend_i    = 1'b0;
    ata_active_i = 1'b1;
    cfg_float_i  = 1'b1;
    repeat (3) @(negedge clk);
    // Reset state: held sample is 0, pin group floats (cfg_float_i=1)
    check("R1", "reset dp_pullup_en", dp_pullup_en_o, 1'b0);
    check("R5", "reset ata_oe", ata_oe_o, 1'b0);
    rst_n = 1'b1;
    exp_v = 1'b0;
    h1    = 1'b0;
    h2    = 1'b0;
    n     = 0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(posedge clk);
      n++;
      // R1, R2, R3: poll at edge 3+kP takes pin level seen at edge n-2
      if (n >= 3 && ((n - 3) % P) == 0) exp_v = h2;
      h2 = h1;
      h1 = vbus_pin;
      @(negedge clk);
      if (n == 2) check("R1", "before first poll", dp_pullup_en_o, 1'b0);
      if (n == 3) check("R1", "first poll", dp_pullup_en_o, 1'b1);
      if (n > 3 && ((n - 3) % P) != 0)
        check("R2", "held between polls", dp_pullup_en_o, exp_v);
      if (n >= 3 && ((n - 3) % P) == 0)
        check("R3", "captured level", dp_pullup_en_o, exp_v);
      check_all(exp_v);
      if (cyc < 3000) begin
        if ($urandom_range(0, 19) == 0) vbus_pin = ~vbus_pin;
        if ($urandom_range(0, 9) == 0) suspend_i = ~suspend_i;
        ata_active_i = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 49) == 0) cfg_float_i = ~cfg_float_i;
      end else begin
        // Directed one-cycle pulses: next edge n+1 is the captured edge when
        // n%P==0 (hit); n%P==1 places the pulse one edge late (miss).
        logic base;
        base = ((cyc / (4 * P)) % 2) == 1;
        if ((n % P) == 0 && ((cyc / P) % 2) == 0)      vbus_pin = ~base;
        else if ((n % P) == 1 && ((cyc / P) % 2) == 1) vbus_pin = ~base;
        else                                           vbus_pin = base;
        cfg_float_i  = ((cyc / (8 * P)) % 2) == 0;
        suspend_i    = 1'($urandom_range(0, 1));
        ata_active_i = 1'($urandom_range(0, 1));
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule